// File: doc/BRIEF.md
# Fractional-N Main Loop Divider

This block divides a VCO-rate clock by a programmable 16-bit integer. Each divider cycle ends in a one-cycle terminal-count pulse, the event the main phase detector compares against the reference. A small fractional accumulator advances by a programmed increment at every terminal count. When it wraps past its modulus, the next divider cycle is one input clock longer. Over a full accumulator round the mean ratio is therefore the integer ratio plus the increment over the modulus. The modulus is selectable between 8 and 5.

The pending ratio, increment and modulus select are sampled only in the terminal-count cycle, so rewriting them never shortens or stretches a cycle already in progress. The terminal-count pulse is therefore also brought out as the load strobe for upstream registers. The accumulator value is an output. A compensation current scaled by it cancels the phase ripple that the ratio switching produces. Dropping the enable parks the divider with the accumulator cleared. Raising it again starts a clean, synchronized cycle.

Top module: `fracn_main_div`

## Requirements
- R1: While `en` is low, `tc_o` and `sync_o` stay low and `frac_idx_o` reads 0.
- R2: After `en` rises, the first `tc_o` pulse falls in the N-th cycle in which `en` is high, where N is the `nmain_in` value present in the last disabled cycle (N from 512 to 65535).
- R3: In the cycle after a `tc_o` cycle, `frac_idx_o` equals the previous index plus `nf_in`, reduced by Q for as many times as needed. Q is 8 when `fmod_in`=0 and 5 when `fmod_in`=1, and both inputs are sampled in the `tc_o` cycle. Between terminal counts the index does not change.
- R4: The cycle count from one `tc_o` to the next equals the `nmain_in` sampled at the first of them. It is one higher when that step's unreduced sum (index plus `nf_in`) was at least Q.
- R5: Changes to `nmain_in`, `nf_in` or `fmod_in` that are undone before the next terminal-count cycle have no effect on pulse timing or on the index.
- R6: `tc_o` is high for exactly one input cycle per divider cycle, and `sync_o` is high in exactly the same cycles.
- R7: `frac_idx_o` is always below the Q selected at the most recent terminal count, including after Q switches from 8 to 5 and when `nf_in` is not below Q.
- R8: Dropping `en` in the middle of a divider cycle abandons that cycle. After re-enable, the accumulator restarts from 0 and the first pulse follows R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-rate input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Divider enable; low parks and clears the divider |
| nmain_in | input | 16 | Pending integer ratio |
| nf_in | input | 3 | Pending fractional increment |
| fmod_in | input | 1 | Pending modulus select: 0 gives 8, 1 gives 5 |
| tc_o | output | 1 | Terminal-count pulse toward the phase detector |
| sync_o | output | 1 | Load strobe for upstream ratio registers |
| frac_idx_o | output | 3 | Fractional accumulator value (compensation index) |

## Verification
The properties assume that `nmain_in` is never below 512. That floor makes back-to-back terminal counts impossible and keeps every counter reload within 16 bits. The properties also assume that `en` is driven synchronously to `clk`. The stimulus uses only ratios of 512 and above and changes every input half a cycle away from the sampling edge. Increments at or above the modulus and a switch from modulus 8 to 5 while the accumulator holds 6 or 7 are applied on purpose. They exercise the repeated-subtraction path inside that legal range.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int N_W     = 16;
  localparam int NF_W    = 3;
  localparam int ACC_W   = 3;
  localparam int Q_BASE  = 8;
  localparam int Q_ALT   = 5;
  localparam int SUM_W   = ACC_W + 1;
  localparam int SUB_MAX = 3;

  typedef struct packed {
    logic             ovf;
    logic [ACC_W-1:0] acc;
  } frac_step_t;

  function automatic logic [SUM_W-1:0] modulus(input logic fmod);
    return fmod ? SUM_W'(Q_ALT) : SUM_W'(Q_BASE);
  endfunction

  function automatic frac_step_t frac_step(input logic [ACC_W-1:0] acc,
                                           input logic [NF_W-1:0]  nf,
                                           input logic             fmod);
    frac_step_t       r;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] q;
    q     = modulus(fmod);
    sum   = SUM_W'(acc) + SUM_W'(nf);
    r.ovf = (sum >= q);
    for (int i = 0; i < SUB_MAX; i++) begin
      if (sum >= q) sum = sum - q;
    end
    r.acc = sum[ACC_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/fracn_acc.sv
module fracn_acc
  import fracn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             step,
  input  logic [NF_W-1:0]  nf,
  input  logic             fmod,
  output logic [ACC_W-1:0] acc,
  output logic             ovf
);
  frac_step_t nxt;

  always_comb nxt = frac_step(acc, nf, fmod);
  assign ovf = nxt.ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (!en)    acc <= '0;
    else if (step)   acc <= nxt.acc;
  end
endmodule

// File: rtl/fracn_cnt.sv
module fracn_cnt
  import fracn_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [N_W-1:0] nmain,
  input  logic           stretch,
  output logic           tc
);
  logic [N_W-1:0] cnt;

  assign tc = en && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!en)  cnt <= nmain - N_W'(1);
    else if (tc)   cnt <= nmain - N_W'(1) + N_W'(stretch);
    else           cnt <= cnt - N_W'(1);
  end
endmodule

// File: rtl/fracn_main_div.sv
module fracn_main_div
  import fracn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [N_W-1:0]   nmain_in,
  input  logic [NF_W-1:0]  nf_in,
  input  logic             fmod_in,
  output logic             tc_o,
  output logic             sync_o,
  output logic [ACC_W-1:0] frac_idx_o
);
  logic cyc_end;
  logic step_ovf;

  fracn_cnt u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .nmain   (nmain_in),
    .stretch (step_ovf),
    .tc      (cyc_end)
  );

  fracn_acc u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .step  (cyc_end),
    .nf    (nf_in),
    .fmod  (fmod_in),
    .acc   (frac_idx_o),
    .ovf   (step_ovf)
  );

  assign tc_o   = cyc_end;
  assign sync_o = cyc_end;
endmodule

// File: rtl/fracn_main_div_chk.sv
module fracn_main_div_chk
  import fracn_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [NF_W-1:0]  nf_in,
  input logic             fmod_in,
  input logic             tc_o,
  input logic [ACC_W-1:0] frac_idx_o
);
  logic             q_is_alt;
  logic [ACC_W-1:0] want_idx;
  int               raw_sum;

  always_comb raw_sum = int'(frac_idx_o) + int'(nf_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_is_alt <= 1'b0;
      want_idx <= '0;
    end else if (tc_o) begin
      q_is_alt <= fmod_in;
      want_idx <= ACC_W'(raw_sum % (fmod_in ? Q_ALT : Q_BASE));
    end
  end

  a_r1_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (frac_idx_o == '0));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |=> !tc_o);

  a_r3_step_value: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_o && en) |=> (frac_idx_o == want_idx));

  a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tc_o) |=> $stable(frac_idx_o));

  a_r7_below_modulus: assert property (@(posedge clk) disable iff (!rst_n)
    int'(frac_idx_o) < (q_is_alt ? Q_ALT : Q_BASE));
endmodule

bind fracn_main_div fracn_main_div_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .nf_in      (nf_in),
  .fmod_in    (fmod_in),
  .tc_o       (tc_o),
  .frac_idx_o (frac_idx_o)
);

// File: tb/fracn_main_div_tb.sv
`timescale 1ns/1ps
module fracn_main_div_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] nmain_in = 16'd512;
  logic [2:0]  nf_in = 3'd0;
  logic        fmod_in = 1'b0;
  logic        tc_o, sync_o;
  logic [2:0]  frac_idx_o;

  fracn_main_div u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .nmain_in(nmain_in), .nf_in(nf_in),
    .fmod_in(fmod_in), .tc_o(tc_o), .sync_o(sync_o), .frac_idx_o(frac_idx_o)
  );

  always #10 clk = ~clk;

  typedef struct {
    int    at;
    int    idx;
    int    q;
    string req;
  } exp_t;

  exp_t  sb[$];
  int    n_tests = 0;
  int    n_fail = 0;
  int    cyc = 0;
  int    m_acc = 0;
  int    exp_next = 0;
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void check(input bit ok, input string req,
                                input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endfunction

  // monitor: pops one expected item per observed terminal count
  bit   pend = 0;
  exp_t cur;
  always @(negedge clk) begin
    if (pend) begin
      pend = 0;
      check(frac_idx_o == cur.idx, {cur.req, "/R3 index"}, frac_idx_o, cur.idx);
      check(frac_idx_o < cur.q, "R7 index below modulus", frac_idx_o, cur.q);
      check(!tc_o, "R6 pulse width", tc_o, 0);
    end
    if (tc_o) begin
      if (sb.size() == 0) begin
        check(0, "R1/R4 unexpected pulse", 1, 0);
      end else begin
        cur = sb.pop_front();
        check(cyc == cur.at, {cur.req, " pulse cycle"}, cyc, cur.at);
        check(sync_o == 1'b1, "R6 sync with pulse", sync_o, 1);
        pend = 1;
      end
    end else if (sync_o) begin
      check(0, "R6 sync without pulse", 1, 0);
    end
  end

  task automatic at_neg();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_cyc(input int target);
    while (cyc < target) at_neg();
  endtask

  // driver: sets the values the next terminal count will sample and pushes its expectation
  task automatic step(input int n, input int nf, input bit fm,
                      input string req, input bit glitch);
    int   q;
    int   sum;
    exp_t e;
    nmain_in = 16'(n);
    nf_in    = 3'(nf);
    fmod_in  = fm;
    q   = fm ? 5 : 8;
    sum = m_acc + nf;
    e.at  = exp_next;
    e.idx = sum % q;
    e.q   = q;
    e.req = req;
    sb.push_back(e);
    if (glitch) begin
      wait_cyc(exp_next - 200);
      nmain_in = 16'(n + 333);
      nf_in    = 3'(nf ^ 5);
      fmod_in  = ~fm;
      wait_cyc(exp_next - 20);
      nmain_in = 16'(n);
      nf_in    = 3'(nf);
      fmod_in  = fm;
    end
    wait_cyc(exp_next + 1);
    m_acc    = sum % q;
    exp_next = exp_next + n + ((sum >= q) ? 1 : 0);
  endtask

  task automatic enable_with(input int n);
    nmain_in = 16'(n);
    at_neg();
    en = 1'b1;
    m_acc = 0;
    exp_next = cyc + n - 1;
  endtask

  initial begin
    repeat (3) at_neg();
    // R1: reset and idle state
    check(tc_o == 0, "R1 no pulse in reset", tc_o, 0);
    check(frac_idx_o == 0, "R1 index zero in reset", frac_idx_o, 0);
    rst_n = 1'b1;
    repeat (5) at_neg();
    check(tc_o == 0 && sync_o == 0, "R1 no pulse while idle", tc_o, 0);
    check(frac_idx_o == 0, "R1 index zero while idle", frac_idx_o, 0);

    // R2 first pulse, then modulus 8 with NF=3 (R3, R4)
    enable_with(512);
    step(512, 3, 1'b0, "R2", 0);
    for (int i = 0; i < 9; i++) step(512, 3, 1'b0, "R4", 0);

    // modulus 5, including switch while index may be >= 5 (R7)
    for (int i = 0; i < 6; i++) step(530, 2, 1'b1, "R7", 0);
    // increment at or above the modulus (R7)
    for (int i = 0; i < 5; i++) step(515, 7, 1'b1, "R7", 0);
    // modulus 8, increment 7: overflow almost every step (R4)
    for (int i = 0; i < 4; i++) step(600, 7, 1'b0, "R4", 0);

    // R5: inputs disturbed mid-cycle and restored before the pulse
    for (int i = 0; i < 3; i++) step(640, 5, 1'b0, "R5", 1);

    // integer-only ratio, large value
    for (int i = 0; i < 2; i++) step(1500, 0, 1'b0, "R4", 0);

    // R8: drop enable mid-cycle, confirm idle, restart
    wait_cyc(cyc + 100);
    en = 1'b0;
    repeat (4) at_neg();
    check(frac_idx_o == 0, "R8 index cleared on disable", frac_idx_o, 0);
    check(tc_o == 0, "R8 no pulse while disabled", tc_o, 0);
    enable_with(520);
    step(520, 1, 1'b1, "R8", 0);
    for (int i = 0; i < 6; i++) step(520, 1, 1'b1, "R4", 0);

    repeat (3) at_neg();
    check(sb.size() == 0, "R4 all expected pulses seen", sb.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      check(0, "watchdog", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule